// File: doc/BRIEF.md
# 16-to-32-bit Host Bus Bridge

This block is a slave bridge between an asynchronous, SRAM-style 16-bit host bus and an internal 32-bit fabric of registers and data FIFOs. Everything runs on one internal clock. The host strobes pass through a multi-flop synchronizer. A host cycle is recognised when the combination of chip-select and a read or write strobe becomes active. The address, data, byte-order and FIFO-mode inputs are sampled at that moment.

Every internal access is 32 bits wide and is built from two back-to-back 16-bit host cycles. Address bit 1 chooses which half a host cycle carries, and the halves may come in either order.

- **Writes.** The first half-word waits in a holding register. One 32-bit write is issued when the second half arrives.
- **Reads.** The 32-bit read is issued on the first cycle and the whole word is latched. The second cycle is served from the latch, so a FIFO is never popped twice.
- **Byte order.** A per-cycle byte-order input swaps the two bytes of the half carried by that cycle.
- **FIFO mode.** A FIFO-mode input overrides the address. Writes go to the transmit data FIFO and reads come from the receive data FIFO.
- **Broken pairs.** If a second cycle does not match its first, the pending half is discarded and a one-cycle error pulse is raised. The new cycle then opens a fresh pair.

Top module: `hbus_bridge16`

## Requirements
- R1: After reset, `acc_req` and `pair_err` are low and `host_dout` is 0.
- R2: A write pair issues exactly one `acc_req` with `acc_we`=1, and it comes after the second cycle, none after the first. The half written with address bit 1 = 0 lands in `acc_wdata[15:0]`, the half written with bit 1 = 1 lands in `[31:16]`, and either order is accepted.
- R3: A read pair issues exactly one `acc_req` with `acc_we`=0, during the first cycle. `host_dout` returns `acc_rdata[15:0]` when address bit 1 = 0 and `acc_rdata[31:16]` when bit 1 = 1. The second cycle is served from the latched word without a new request.
- R4: When `host_big_end`=1 during a cycle, the two bytes of that cycle's half are swapped, on both write data and read data. Each cycle of a pair uses its own sample, so mixed byte order within a pair is allowed.
- R5: When `host_fifo_mode`=1, writes target the TX data FIFO (`acc_tgt`=1) and reads target the RX data FIFO (`acc_tgt`=2), with `acc_addr`=0 whatever the host address.
- R6: When `host_fifo_mode`=0 and the word address `host_addr[ADDR_W-1:2]` is below `DFIFO_WORDS`, writes target the TX data FIFO (1) and reads the RX data FIFO (2). Other word addresses target registers (`acc_tgt`=0). In both cases `acc_addr` equals the word address.
- R7: A second cycle whose direction, FIFO-mode input, word address (ignored in FIFO mode) or address bit 1 matches wrongly against the pending first cycle raises `pair_err` for one cycle. The pending half is dropped, and the new cycle becomes the first of a new pair. Address bit 1 matches wrongly when it equals the first cycle's value.
- R8: Each host strobe assertion is recognised exactly once, however long it is held, and every `acc_req` lasts one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | ADDR_W-1 | Host address bits ADDR_W-1 down to 1 |
| host_din | input | 16 | Host write data |
| host_dout | output | 16 | Host read data |
| host_big_end | input | 1 | 1 selects big-endian byte order for this cycle |
| host_fifo_mode | input | 1 | 1 steers the access to the data FIFOs |
| acc_req | output | 1 | One-cycle internal access request |
| acc_we | output | 1 | 1 = write, 0 = read |
| acc_tgt | output | 2 | 0 registers, 1 TX data FIFO, 2 RX data FIFO |
| acc_addr | output | ADDR_W-2 | Internal word address |
| acc_wdata | output | 32 | Internal write data |
| acc_rdata | input | 32 | Internal read data, valid in the cycle of `acc_req` |
| pair_err | output | 1 | One-cycle pulse when a pair is broken |

## Verification
The assertions assume that the host holds address, data, byte-order and FIFO-mode inputs stable for as long as the strobe is asserted. They also assume that consecutive strobe assertions are separated by an inactive gap longer than the synchronizer depth. A further assumption is that the fabric answers a read combinationally in the request cycle. The bench keeps to this by changing every host input only while the strobes are released. It holds each strobe for several clocks, leaves several idle clocks between cycles, and models the fabric as an arithmetic function of target and address. The sweep covers every word address, both half orders, all byte-order combinations, both FIFO modes and both directions, and then deliberately breaks pairs.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
   typedef enum logic [1:0] {
      TGT_REG = 2'd0,
      TGT_TXD = 2'd1,
      TGT_RXD = 2'd2
   } tgt_e;

   // byte swap of one half-word when big-endian ordering is selected (R4)
   function automatic logic [15:0] half_swap(input logic big, input logic [15:0] h);
      return big ? {h[7:0], h[15:8]} : h;
   endfunction
endpackage

// File: rtl/hbb_sync.sv
module hbb_sync #(
   parameter int              W       = 3,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    INIT    = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= INIT;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= INIT;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/hbb_decode.sv
module hbb_decode
   import hbb_pkg::*;
#(
   parameter int WAW         = 4,
   parameter int DFIFO_WORDS = 4
) (
   input  logic           we,
   input  logic           fsel,
   input  logic [WAW-1:0] wa,
   output tgt_e           tgt,
   output logic [WAW-1:0] addr_o
);
   localparam logic [WAW:0] DFW_L = (WAW+1)'(DFIFO_WORDS);

   always_comb begin
      if (fsel) begin                       // R5: address bypassed
         tgt    = we ? TGT_TXD : TGT_RXD;
         addr_o = '0;
      end else if ({1'b0, wa} < DFW_L) begin // R6: data FIFO window
         tgt    = we ? TGT_TXD : TGT_RXD;
         addr_o = wa;
      end else begin                        // R6: register space
         tgt    = TGT_REG;
         addr_o = wa;
      end
   end
endmodule

// File: rtl/hbb_pair_ctrl.sv
module hbb_pair_ctrl
   import hbb_pkg::*;
#(
   parameter int WAW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           we,
   input  logic           a1,
   input  logic [WAW-1:0] wa,
   input  logic           fsel,
   input  logic           big,
   input  logic [15:0]    din,
   input  logic [31:0]    rdata,
   output logic           iss,
   output logic           iss_we,
   output logic [WAW-1:0] iss_wa,
   output logic           iss_fsel,
   output logic [31:0]    iss_wdata,
   output logic           err,
   output logic [15:0]    dout
);
   logic           pend_q, pend_we_q, pend_a1_q, pend_fs_q;
   logic [WAW-1:0] pend_wa_q;
   logic [15:0]    hold_q;
   logic [31:0]    rlatch_q;
   logic           cur_a1_q, cur_big_q;
   logic           match;
   logic [15:0]    din_sw;

   assign din_sw = half_swap(big, din);

   // R7: second cycle must agree with the pending first one
   assign match = pend_q && (we == pend_we_q) && (fsel == pend_fs_q)
                  && (a1 != pend_a1_q) && (fsel || (wa == pend_wa_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         pend_we_q <= 1'b0;
         pend_a1_q <= 1'b0;
         pend_fs_q <= 1'b0;
         pend_wa_q <= '0;
         hold_q    <= '0;
         rlatch_q  <= '0;
         cur_a1_q  <= 1'b0;
         cur_big_q <= 1'b0;
         iss       <= 1'b0;
         iss_we    <= 1'b0;
         iss_wa    <= '0;
         iss_fsel  <= 1'b0;
         iss_wdata <= '0;
         err       <= 1'b0;
      end else begin
         iss <= 1'b0;
         err <= 1'b0;
         if (iss && !iss_we) rlatch_q <= rdata;        // R3: latch whole word
         if (start) begin
            cur_a1_q  <= a1;
            cur_big_q <= big;
            if (match) begin
               pend_q <= 1'b0;
               if (we) begin                           // R2: single write
                  iss       <= 1'b1;
                  iss_we    <= 1'b1;
                  iss_wa    <= wa;
                  iss_fsel  <= fsel;
                  iss_wdata <= a1 ? {din_sw, hold_q} : {hold_q, din_sw};
               end
            end else begin
               err       <= pend_q;                     // R7
               pend_q    <= 1'b1;
               pend_we_q <= we;
               pend_a1_q <= a1;
               pend_fs_q <= fsel;
               pend_wa_q <= wa;
               hold_q    <= din_sw;
               if (!we) begin                           // R3: read on first half
                  iss      <= 1'b1;
                  iss_we   <= 1'b0;
                  iss_wa   <= wa;
                  iss_fsel <= fsel;
               end
            end
         end
      end
   end

   assign dout = half_swap(cur_big_q, cur_a1_q ? rlatch_q[31:16] : rlatch_q[15:0]);

   // R8: requests are single-cycle pulses
   assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      iss |=> !iss);
   // R2: a write is only issued while a write half was pending
   assert_write_after_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (iss && iss_we) |-> $past(pend_q && pend_we_q));
   // R3: second read half never re-reads the fabric
   assert_no_reread_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && match && !we) |=> !iss);
   // R7: error only when a pair was open
   assert_err_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past(pend_q && start));
   assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
endmodule

// File: rtl/hbus_bridge16.sv
module hbus_bridge16
   import hbb_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int DFIFO_WORDS = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs_n,
   input  logic              host_rd_n,
   input  logic              host_wr_n,
   input  logic [ADDR_W-1:1] host_addr,
   input  logic [15:0]       host_din,
   output logic [15:0]       host_dout,
   input  logic              host_big_end,
   input  logic              host_fifo_mode,
   output logic              acc_req,
   output logic              acc_we,
   output logic [1:0]        acc_tgt,
   output logic [ADDR_W-3:0] acc_addr,
   output logic [31:0]       acc_wdata,
   input  logic [31:0]       acc_rdata,
   output logic              pair_err
);
   localparam int WAW = ADDR_W - 2;

   initial begin
      assert (ADDR_W >= 4) else $error("ADDR_W must be at least 4");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (DFIFO_WORDS >= 0 && DFIFO_WORDS <= (1 << WAW))
         else $error("DFIFO_WORDS exceeds the word address space");
   end

   logic [2:0]     strb_s;
   logic           act, act_d, start, we;
   logic           iss_we, iss_fsel;
   logic [WAW-1:0] iss_wa;
   tgt_e           tgt;

   hbb_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   ({host_cs_n, host_rd_n, host_wr_n}),
      .q   (strb_s)
   );

   assign act   = !strb_s[2] && (!strb_s[1] || !strb_s[0]);
   assign we    = !strb_s[0];
   assign start = act && !act_d;                      // R8: one start per assertion

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_d <= 1'b0;
      else        act_d <= act;
   end

   hbb_pair_ctrl #(.WAW(WAW)) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .we        (we),
      .a1        (host_addr[1]),
      .wa        (host_addr[ADDR_W-1:2]),
      .fsel      (host_fifo_mode),
      .big       (host_big_end),
      .din       (host_din),
      .rdata     (acc_rdata),
      .iss       (acc_req),
      .iss_we    (iss_we),
      .iss_wa    (iss_wa),
      .iss_fsel  (iss_fsel),
      .iss_wdata (acc_wdata),
      .err       (pair_err),
      .dout      (host_dout)
   );

   hbb_decode #(.WAW(WAW), .DFIFO_WORDS(DFIFO_WORDS)) u_dec (
      .we     (iss_we),
      .fsel   (iss_fsel),
      .wa     (iss_wa),
      .tgt    (tgt),
      .addr_o (acc_addr)
   );

   assign acc_we  = iss_we;
   assign acc_tgt = tgt;

   // R8: a recognised cycle cannot restart on the next clock
   assert_start_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
   // R5/R6: FIFO direction follows access direction
   assert_txd_is_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && acc_tgt == TGT_TXD) |-> acc_we);
   assert_rxd_is_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && acc_tgt == TGT_RXD) |-> !acc_we);
   assert_no_req_in_reset_R1: assert property (@(posedge clk)
      !rst_n |-> !acc_req);
endmodule

// File: tb/tb_hbus_bridge16.sv
`timescale 1ns/1ps
module tb_hbus_bridge16;
   localparam int AW  = 6;
   localparam int WAW = AW - 2;
   localparam int DFW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
   logic [AW-1:1] host_addr = '0;
   logic [15:0] host_din = '0;
   logic [15:0] host_dout;
   logic host_big_end = 1'b0, host_fifo_mode = 1'b0;
   logic acc_req, acc_we, pair_err;
   logic [1:0] acc_tgt;
   logic [WAW-1:0] acc_addr;
   logic [31:0] acc_wdata, acc_rdata;

   always #2.5 clk = ~clk;

   hbus_bridge16 #(.ADDR_W(AW), .DFIFO_WORDS(DFW), .SYNC_STAGES(2)) dut (.*);

   function automatic logic [31:0] model(input logic [1:0] t, input logic [WAW-1:0] a);
      return (32'h13579BDF * (32'(a) + 32'd1)) ^ {30'd0, t};
   endfunction
   assign acc_rdata = model(acc_tgt, acc_addr);

   function automatic logic [15:0] sw(input logic big, input logic [15:0] h);
      return big ? {h[7:0], h[15:8]} : h;
   endfunction
   function automatic logic [1:0] etgt(input logic we, input logic fs, input int wa);
      if (fs || wa < DFW) return we ? 2'd1 : 2'd2;
      return 2'd0;
   endfunction

   int nchk = 0, nfail = 0, nreq = 0, nerr = 0;
   logic l_we; logic [1:0] l_tgt; logic [WAW-1:0] l_addr; logic [31:0] l_wd;

   always @(negedge clk) if (rst_n) begin
      if (acc_req) begin
         nreq++; l_we = acc_we; l_tgt = acc_tgt; l_addr = acc_addr; l_wd = acc_wdata;
      end
      if (pair_err) nerr++;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hcyc(input logic we, input int wa, input logic a1, input logic big,
                       input logic fs, input logic [15:0] d, output logic [15:0] q);
      @(negedge clk);
      host_addr = {wa[WAW-1:0], a1}; host_din = d; host_big_end = big; host_fifo_mode = fs;
      host_cs_n = 1'b0;
      if (we) host_wr_n = 1'b0; else host_rd_n = 1'b0;
      repeat (7) @(negedge clk);
      q = host_dout;
      host_cs_n = 1'b1; host_wr_n = 1'b1; host_rd_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", nchk, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      logic [15:0] q1, q2, d1, d2;
      logic [31:0] w;
      int r0, e0;
      repeat (3) @(negedge clk);
      chk("R1 req", 32'(acc_req), 0);
      chk("R1 err", 32'(pair_err), 0);
      chk("R1 dout", 32'(host_dout), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      for (int wa = 0; wa < (1 << WAW); wa++)
         for (int a1 = 0; a1 < 2; a1++)
            for (int e = 0; e < 4; e++)
               for (int fs = 0; fs < 2; fs++)
                  for (int we = 0; we < 2; we++) begin
                     string tt;
                     tt = fs ? "R5" : "R6";
                     d1 = 16'(wa * 4099 + e * 257 + fs * 31 + a1);
                     d2 = ~d1 ^ 16'h5a00;
                     r0 = nreq; e0 = nerr;
                     w  = model(etgt(we[0], fs[0], wa), fs ? '0 : WAW'(wa));
                     hcyc(we[0], wa, a1[0], e[0], fs[0], d1, q1);
                     if (we) chk("R2 no write after first half", 32'(nreq - r0), 0);
                     else begin
                        chk("R3 read on first half", 32'(nreq - r0), 1);
                        chk("R4 R3 first read half", 32'(q1),
                            32'(sw(e[0], a1 ? w[31:16] : w[15:0])));
                     end
                     hcyc(we[0], wa, !a1[0], e[1], fs[0], d2, q2);
                     chk("R8 one request per pair", 32'(nreq - r0), 1);
                     chk({tt, " target"}, 32'(l_tgt), 32'(etgt(we[0], fs[0], wa)));
                     chk({tt, " address"}, 32'(l_addr), fs ? 0 : 32'(wa));
                     chk("R2 direction", 32'(l_we), 32'(we));
                     chk("R7 no error on good pair", 32'(nerr - e0), 0);
                     if (we)
                        chk("R4 R2 write word", l_wd, a1 ? {sw(e[0], d1), sw(e[1], d2)}
                                                         : {sw(e[1], d2), sw(e[0], d1)});
                     else
                        chk("R4 R3 second read half", 32'(q2),
                            32'(sw(e[1], a1 ? w[15:0] : w[31:16])));
                  end

      // R7: direction change breaks the pair, read starts afresh
      r0 = nreq; e0 = nerr;
      hcyc(1'b1, 2, 1'b0, 1'b0, 1'b0, 16'h1111, q1);
      hcyc(1'b0, 2, 1'b1, 1'b0, 1'b0, 16'h0, q1);
      chk("R7 error on direction change", 32'(nerr - e0), 1);
      chk("R7 broken cycle starts new read", 32'(nreq - r0), 1);
      hcyc(1'b0, 2, 1'b0, 1'b0, 1'b0, 16'h0, q2);
      w = model(2'd2, 4'd2);
      chk("R7 new pair completes", 32'({q1, q2}), w);
      chk("R7 no extra error", 32'(nerr - e0), 1);

      // R7: word address change drops the pending half
      r0 = nreq; e0 = nerr;
      hcyc(1'b1, 5, 1'b0, 1'b0, 1'b0, 16'h1111, q1);
      hcyc(1'b1, 6, 1'b1, 1'b0, 1'b0, 16'h2222, q1);
      chk("R7 error on address change", 32'(nerr - e0), 1);
      chk("R7 no write on broken pair", 32'(nreq - r0), 0);
      hcyc(1'b1, 6, 1'b0, 1'b0, 1'b0, 16'h3333, q1);
      chk("R7 write uses new pair only", l_wd, 32'h2222_3333);
      chk("R7 write address", 32'(l_addr), 6);

      // R7: same address bit 1 twice
      r0 = nreq; e0 = nerr;
      hcyc(1'b1, 9, 1'b1, 1'b0, 1'b0, 16'hAAAA, q1);
      hcyc(1'b1, 9, 1'b1, 1'b0, 1'b0, 16'hBBBB, q1);
      chk("R7 error on repeated half", 32'(nerr - e0), 1);
      hcyc(1'b1, 9, 1'b0, 1'b0, 1'b0, 16'hCCCC, q1);
      chk("R7 repeated half replaced", l_wd, 32'hBBBB_CCCC);
      chk("R7 one write", 32'(nreq - r0), 1);

      // R7: FIFO-mode input change
      r0 = nreq; e0 = nerr;
      hcyc(1'b1, 0, 1'b0, 1'b0, 1'b1, 16'h4444, q1);
      hcyc(1'b1, 0, 1'b1, 1'b0, 1'b0, 16'h5555, q1);
      chk("R7 error on mode change", 32'(nerr - e0), 1);
      chk("R7 no write on mode change", 32'(nreq - r0), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule